// File: doc/BRIEF.md
# Reloading Interval Timer with Interrupt

This block is a 16-bit down-counting interval timer that sits on a byte-wide CPU register bus. Software stores a reload value in two byte latches. Writing the upper byte copies both latches into the counter and starts a countdown. Each timeout sets an interrupt flag. When interrupts are enabled, the flag drives an active-low interrupt line. A control bit chooses between two modes. In continuous mode the counter reloads itself, so the period is the reload value plus two cycles. In one-shot mode the timer signals only once for each start.

Software acknowledges a timeout by reading the lower counter byte. A second control bit makes a dedicated output pin invert on every signalled timeout, which produces a square wave with no software help. The register window is 16 bytes wide. Only the offsets listed in the requirements are decoded, and every other offset reads as zero.

Top module: `ivt_timer`

## Requirements
- R1: After reset, irq_n and tog_out are high, and the control register (offset 0xB), status register (offset 0xD) and enable register (offset 0xE) all read 0.
- R2: A write to offset 0x5 stores the byte as the upper latch and loads the counter with {written byte, lower latch}. The write also clears the flag and arms the timer. In the next cycle the counter reads back with its low byte at offset 0x4 and its high byte at offset 0x5.
- R3: Apart from loads and reloads, the counter drops by one each cycle. A timeout is the step from 0 to 0xFFFF. A load of N at a clock edge gives a signalled timeout at the edge N+1 cycles later.
- R4: When control bit 0 is 1 (continuous mode), the counter reloads from the latches in the cycle after a timeout, so signalled timeouts repeat every N+2 cycles.
- R5: When control bit 0 is 0 (one-shot mode), only the first timeout after a load is signalled. The counter keeps decrementing and wraps. A new write to offset 0x5 re-arms the timer.
- R6: Status bit 0 (offset 0xD) shows the raw flag. irq_n is low exactly when the flag is set and enable bit 0 (offset 0xE) is 1.
- R7: A read of offset 0x4 clears the flag at that clock edge. If a signalled timeout falls on the same edge, the flag is set instead.
- R8: When control bit 1 is 1, tog_out inverts on every signalled timeout. tog_out resets high.
- R9: A write to offset 0x5 on the same edge as a timeout wins. The counter takes the new value, the flag stays clear and no reload follows.
- R10: Offsets 0x6 and 0x7 read and write the lower and upper latches without touching the counter or the flag. A write to offset 0x4 sets the lower latch. All offsets not named here read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not reading |
| irq_n | output | 1 | Active-low interrupt |
| tog_out | output | 1 | Square-wave output |

## Verification
Read data is combinational, so the bench samples it in the same cycle the read is presented. A counter load shows up one edge after the upper-byte write. The first flag and toggle appear at the edge N+1 cycles after the load edge, and later ones follow every N+2 edges in continuous mode. A flag clear by read takes effect at the edge that ends the read cycle. The bench counts edges since each load and predicts the counter value, flag and toggle level for every cycle from those offsets. It samples on the falling edge, half a period after each commit.

// File: rtl/ivt_pkg.sv
// Package: shared widths, register offsets and control bit positions for the
// interval timer. Assumes a byte-wide bus with a 4-bit register offset.
package ivt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 4'h5;
    localparam logic [ADDR_W-1:0] OFF_LAT_LO = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_LAT_HI = 4'h7;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'hB;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 4'hD;
    localparam logic [ADDR_W-1:0] OFF_ENA    = 4'hE;

    localparam int CTRL_CONT_BIT = 0;
    localparam int CTRL_TOG_BIT  = 1;

    typedef struct packed {
        logic cont;
        logic tog_en;
        logic irq_en;
    } ivt_cfg_t;
endpackage

// File: rtl/ivt_regs.sv
// Register decode: holds the latches and configuration bits, produces the
// load and flag-clear strobes, and returns read data. Assumes one access per
// cycle and read data consumed combinationally in the same cycle.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [2*DW-1:0] cnt,
    input  logic          flag,
    output logic [2*DW-1:0] latch,
    output logic [2*DW-1:0] load_val,
    output logic          load,
    output logic          rd_clr,
    output ivt_cfg_t      cfg,
    output logic [DW-1:0] bus_rdata
);
    logic [DW-1:0] lat_lo, lat_hi;
    logic          wr_en, rd_en;

    // Access qualifiers and strobes seen by the counter and flag logic.
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;
        load     = wr_en && (bus_addr == OFF_CNT_HI);
        rd_clr   = rd_en && (bus_addr == OFF_CNT_LO);
        load_val = {bus_wdata, lat_lo};
        latch    = {lat_hi, lat_lo};
    end

    // Latch and configuration storage written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_lo <= '0;
            lat_hi <= '0;
            cfg    <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFF_CNT_LO, OFF_LAT_LO: lat_lo <= bus_wdata;
                OFF_CNT_HI, OFF_LAT_HI: lat_hi <= bus_wdata;
                OFF_CTRL: begin
                    cfg.cont   <= bus_wdata[CTRL_CONT_BIT];
                    cfg.tog_en <= bus_wdata[CTRL_TOG_BIT];
                end
                OFF_ENA:  cfg.irq_en <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    // Read multiplexer; idle bus and undecoded offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFF_CNT_LO: bus_rdata = cnt[DW-1:0];
                OFF_CNT_HI: bus_rdata = cnt[2*DW-1:DW];
                OFF_LAT_LO: bus_rdata = lat_lo;
                OFF_LAT_HI: bus_rdata = lat_hi;
                OFF_CTRL: begin
                    bus_rdata[CTRL_CONT_BIT] = cfg.cont;
                    bus_rdata[CTRL_TOG_BIT]  = cfg.tog_en;
                end
                OFF_STAT:   bus_rdata[0] = flag;
                OFF_ENA:    bus_rdata[0] = cfg.irq_en;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2: the upper latch follows the byte written with a load.
    assert_hi_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> lat_hi == $past(bus_wdata));
    // R10: writes to the plain latch offsets never raise the load strobe.
    assert_latch_noload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == OFF_LAT_HI || bus_addr == OFF_LAT_LO)) |-> !load);
endmodule

// File: rtl/ivt_counter.sv
// Down counter with automatic reload and one-shot arming. A timeout is the
// step from zero to all ones; it is signalled when continuous mode is set or
// the timer is armed. Assumes load has priority over everything else.
module ivt_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] latch,
    input  logic          cont,
    output logic [CW-1:0] cnt,
    output logic          fire
);
    logic reload_pend;
    logic armed;
    logic timeout;

    // Timeout detection and signalled-event qualification.
    always_comb begin
        timeout = (cnt == '0) && !load && !reload_pend;
        fire    = timeout && (cont || armed);
    end

    // Counter, reload request and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '1;
            reload_pend <= 1'b0;
            armed       <= 1'b0;
        end else if (load) begin
            cnt         <= load_val;
            reload_pend <= 1'b0;
            armed       <= 1'b1;
        end else if (reload_pend) begin
            cnt         <= latch;
            reload_pend <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
            if (timeout && cont) reload_pend <= 1'b1;
            if (fire)            armed       <= 1'b0;
        end
    end

    // R2 / R9: a load always wins and lands next cycle.
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R3: plain cycles step down by one.
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !reload_pend) |=> cnt == $past(cnt) - 1'b1);
    // R4: continuous timeout is followed by a reload from the latches.
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && cont) ##1 !load |=> cnt == $past(latch));
    // R5: one-shot mode signals only once per arming.
    assert_single_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cont) |=> !armed);
endmodule

// File: rtl/ivt_irq.sv
// Interrupt flag, gated active-low request and square-wave toggle. Assumes
// fire and load are never active together (the counter gates that case).
module ivt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic load,
    input  logic rd_clr,
    input  logic irq_en,
    input  logic tog_en,
    output logic flag,
    output logic irq_n,
    output logic tog_out
);
    // Flag: load clears, timeout sets, counter-low read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (load)   flag <= 1'b0;
        else if (fire)   flag <= 1'b1;
        else if (rd_clr) flag <= 1'b0;
    end

    // Square-wave output inverts on each signalled timeout when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                tog_out <= 1'b1;
        else if (fire && tog_en)   tog_out <= !tog_out;
    end

    // Interrupt request gated by the enable bit.
    always_comb irq_n = !(flag && irq_en);

    // R3: a signalled timeout leaves the flag set.
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag);
    // R7: a counter-low read without a coincident timeout clears the flag.
    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !fire && !load) |=> !flag);
    // R8: toggle output inverts on enabled timeouts.
    assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tog_en) |=> tog_out != $past(tog_out));
    // R8: without a timeout the toggle output holds.
    assert_tog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(tog_out));
endmodule

// File: rtl/ivt_timer.sv
// Top of the interval timer: register decode, counter and interrupt logic.
// Assumes a synchronous byte bus with single-cycle accesses.
module ivt_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n,
    output logic              tog_out
);
    logic [CNT_W-1:0] cnt, latch, load_val;
    logic             load, rd_clr, fire, flag;
    ivt_cfg_t         cfg;

    ivt_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .flag(flag),
        .latch(latch), .load_val(load_val), .load(load), .rd_clr(rd_clr),
        .cfg(cfg), .bus_rdata(bus_rdata)
    );

    ivt_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .latch(latch), .cont(cfg.cont), .cnt(cnt), .fire(fire)
    );

    ivt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .load(load), .rd_clr(rd_clr),
        .irq_en(cfg.irq_en), .tog_en(cfg.tog_en), .flag(flag),
        .irq_n(irq_n), .tog_out(tog_out)
    );

    // R6: the request line is never active with the enable bit clear.
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |-> irq_n);
    // R1: outputs come out of reset in their idle state.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && tog_out));
endmodule

// File: tb/tb_ivt_timer.sv
module tb_ivt_timer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n, tog_out;

    int total = 0, bad = 0;
    bit done = 0;

    ivt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .tog_out(tog_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge, one clock edge apart.
    task automatic idle();
        bus_sel = 0; bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Expected counter value k edges after a load of n.
    function automatic int cnt_exp(input int n, input bit cont, input int k);
        int p;
        if (!cont) return (n - k) & 16'hFFFF;
        p = k % (n + 2);
        return (p <= n) ? (n - p) : 16'hFFFF;
    endfunction

    // Whether the edge k after a load carries a signalled timeout.
    function automatic bit fire_at(input int n, input bit cont, input int k);
        if (k < n + 1) return 0;
        if (!cont) return k == n + 1;
        return ((k - (n + 1)) % (n + 2)) == 0;
    endfunction

    task automatic trial(input int n, input bit cont, input bit ie, input bit tg, input int steps);
        bit flag_e;
        bit tog_e;
        logic [7:0] d;
        wr(4'hB, {6'b0, tg, cont});
        wr(4'hE, {7'b0, ie});
        wr(4'h4, n[7:0]);
        wr(4'h5, n[15:8]);
        flag_e = 0;
        tog_e  = tog_out;
        for (int k = 0; k < steps; k++) begin
            int act;
            act = $urandom % 8;
            if (cont && k == 2*n + 2) act = 0;
            chk(irq_n == !(flag_e && ie), "R6 irq_n", irq_n, !(flag_e && ie));
            chk(tog_out == tog_e, "R8 tog_out", tog_out, tog_e);
            if (act == 0) begin
                rd(4'h4, d);
                chk(d == cnt_exp(n, cont, k) % 256, cont ? "R4 cnt lo" : "R5 cnt lo", d, cnt_exp(n, cont, k) % 256);
            end else if (act == 1) begin
                rd(4'h5, d);
                chk(d == cnt_exp(n, cont, k) / 256, "R3 cnt hi", d, cnt_exp(n, cont, k) / 256);
            end else if (act == 2) begin
                rd(4'hD, d);
                chk(d == {7'b0, flag_e}, "R6 status", d, flag_e);
            end else begin
                idle();
            end
            if (fire_at(n, cont, k + 1)) begin
                flag_e = 1;
                if (tg) tog_e = !tog_e;
            end else if (act == 0) begin
                flag_e = 0;   // R7 clear, set wins on coincidence
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq_n == 1, "R1 irq_n", irq_n, 1);
        chk(tog_out == 1, "R1 tog_out", tog_out, 1);
        rd(4'hB, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(4'hD, d); chk(d == 0, "R1 status", d, 0);
        rd(4'hE, d); chk(d == 0, "R1 enable", d, 0);

        // R10 latch access, no effect on counter load or flag
        wr(4'h6, 8'hAB); wr(4'h7, 8'hCD);
        rd(4'h6, d); chk(d == 8'hAB, "R10 latch lo", d, 8'hAB);
        rd(4'h7, d); chk(d == 8'hCD, "R10 latch hi", d, 8'hCD);
        rd(4'h3, d); chk(d == 0, "R10 unused", d, 0);
        rd(4'hF, d); chk(d == 0, "R10 unused", d, 0);

        // R2 load and immediate readback
        wr(4'hB, 8'h00); wr(4'h4, 8'h34); wr(4'h5, 8'h12);
        rd(4'h5, d); chk(d == 8'h12, "R2 load hi", d, 8'h12);
        rd(4'h7, d); chk(d == 8'h12, "R2 upper latch", d, 8'h12);

        // R9 write on the timeout edge wins
        wr(4'hB, 8'h01); wr(4'hE, 8'h01); wr(4'h4, 8'h05); wr(4'h5, 8'h00);
        repeat (5) idle();
        wr(4'h5, 8'h00);
        chk(irq_n == 1, "R9 irq_n", irq_n, 1);
        rd(4'hD, d); chk(d == 0, "R9 status", d, 0);
        rd(4'h4, d); chk(d == 4, "R9 cnt", d, 4);
        repeat (3) idle();
        chk(irq_n == 1, "R9 before timeout", irq_n, 1);
        idle();
        chk(irq_n == 0, "R9 timeout after reload", irq_n, 0);

        // R5 one-shot, no repeat, re-arm by upper write
        wr(4'hB, 8'h00); wr(4'h4, 8'h03); wr(4'h5, 8'h00);
        repeat (4) idle();
        chk(irq_n == 0, "R5 first timeout", irq_n, 0);
        rd(4'h4, d); chk(d == 8'hFF, "R5 wrap", d, 8'hFF);
        repeat (12) idle();
        chk(irq_n == 1, "R5 no repeat", irq_n, 1);
        wr(4'h5, 8'h00);
        repeat (4) idle();
        chk(irq_n == 0, "R5 re-armed", irq_n, 0);
        wr(4'h7, 8'h00);
        chk(irq_n == 0, "R10 latch write keeps flag", irq_n, 0);

        // Random trials over R3, R4, R5, R6, R7, R8
        for (int t = 0; t < 40; t++) begin
            int n;
            bit c;
            n = $urandom % 61;
            c = $urandom % 2;
            trial(n, c, $urandom % 2, $urandom % 2, 3 * (n + 2) + 2);
        end
        trial(1, 1, 1, 1, 20);
        trial(0, 1, 1, 1, 12);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule